// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block places a 64x64 cursor image with two bits per pixel on top of the display pixel stream. Software programs a small set of cursor registers through a write port: where the map sits in video memory (a DWORD address), a coarse position, fine X and Y offsets, two colors, a first used map column, a count of displayed rows and an enable bit. The coarse position is a DWORD address into the frame buffer. The block turns it back into a coarse column and row, then adds the offsets to get the cursor corner on screen.

During horizontal blanking the raster timing pulses `ln_go` and gives the row number of the coming line. If that line crosses the cursor, a fetch state machine reads the four DWORDs of the matching map row over a request/acknowledge port into a 128-bit row buffer. The states are S_IDLE (no cursor on this line), S_FETCH (reading map words) and S_SHOW (row buffer valid). `ln_go` moves any state to S_FETCH on a hit and to S_IDLE otherwise. S_FETCH moves to S_SHOW when the fourth word is acknowledged. S_FETCH falls back to S_IDLE if active video starts before the fetch is done. During the active line, each pixel is replaced by the background color, the foreground color, the display pixel itself, or the inverted display pixel, according to its map code. Every output pixel is registered exactly once, whether it was replaced or not.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is asserted and after it, until the first active pixel, `pix_out` is 0 and `mem_req` is low.
- R2: A write with `wr_en` high loads the register named by `wr_sel`. The select codes are:
  - 0: map address bits 15:0.
  - 1: map address bits 30:16 in data bits 14:0, and the enable in bit 15.
  - 2: coarse position bits 15:0.
  - 3: coarse position bits 31:16.
  - 4: X offset.
  - 5: Y offset.
  - 6: foreground color in bits 7:0 and background color in bits 15:8.
  - 7: first used column in bits 5:0 and displayed row count in bits 13:8.
- R3: With P the 32-bit coarse position, the cursor corner is row Y = (4·P >> LINE_LG) + Y offset and column X = ((4·P mod 2^LINE_LG) >> PIX_LG) + X offset, both modulo 2^CNT_W.
- R4: When `ln_go` names a line y with y ≥ Y, y−Y < row count and the cursor enabled, the block issues exactly four requests at addresses base + 4·(y−Y) + w for w = 0,1,2,3, in that order. Each request is held until `mem_ack`.
- R5: In map word w, bits 2j+1:2j hold the code of map column 16·w + j.
- R6: The map codes are 00 for the background color, 01 for the foreground color, 10 for transparent (display pixel unchanged), and 11 for the bitwise inverse of the display pixel.
- R7: Screen column X + k shows map column first + k, only while first + k ≤ 63. Columns left of X are not touched.
- R8: Lines at or beyond the row count, or above Y, are not overlaid and cause no memory request.
- R9: `pix_out` equals `pix_in` of the previous cycle whenever the cursor is disabled, `pix_active` is low, or the pixel is outside the cursor. The latency is one cycle in every case.
- R10: If `pix_active` rises before the fourth word is acknowledged, the fetch is abandoned, no further request is made, and the whole line passes through.
- R11: `mem_req` rises only in the cycle after an `ln_go` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| ln_go | input | 1 | Blanking pulse that starts the next-line lookup |
| ln_y | input | CNT_W | Row number of the next active line |
| pix_active | input | 1 | Active video qualifier |
| pix_x | input | CNT_W | Column of the current pixel |
| pix_in | input | COL_W | Incoming display pixel |
| pix_out | output | COL_W | Overlaid pixel, one cycle later |
| mem_req | output | 1 | Map word request |
| mem_addr | output | ADR_W | DWORD address of the requested map word |
| mem_ack | input | 1 | Request accepted, data valid |
| mem_rdata | input | 32 | Map word |

## Verification
The in-line assertions cover the properties that hold on every cycle:
- The one-cycle bypass whenever the cursor is off or video is blanked.
- Requests are held until acknowledged.
- No request appears without a preceding `ln_go`.
- A fetch stops once active video begins.

Only the bench scenarios can show the rest. These are the position decode from the coarse address, the word order and bit layout of the map, the effect of each of the four codes, and clipping by first column and row count. A scoreboard compares every pixel of several lines against a model computed from the register values.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
    localparam int MAP_DIM  = 64;
    localparam int FLD_W    = $clog2(MAP_DIM);
    localparam int ROW_BITS = MAP_DIM * 2;
    localparam int WORDS    = ROW_BITS / 32;
    localparam int WIDX_W   = $clog2(WORDS);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_SHOW  = 2'd2
    } fetch_st_t;

    typedef enum logic [1:0] {
        C_BG    = 2'b00,
        C_FG    = 2'b01,
        C_CLEAR = 2'b10,
        C_INV   = 2'b11
    } code_t;
endpackage

// File: rtl/cur_regs.sv
module cur_regs
    import cursor_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int COL_W   = 8,
    parameter int ADR_W   = 31,
    parameter int LINE_LG = 10,
    parameter int PIX_LG  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [15:0]        wr_data,
    output logic               en,
    output logic [ADR_W-1:0]   base,
    output logic [CNT_W-1:0]   cur_x,
    output logic [CNT_W-1:0]   cur_y,
    output logic [COL_W-1:0]   fg,
    output logic [COL_W-1:0]   bg,
    output logic [FLD_W-1:0]   first,
    output logic [FLD_W-1:0]   lines
);
    localparam int BA_W = 34;
    localparam logic [BA_W-1:0] LMASK = (BA_W'(1) << LINE_LG) - BA_W'(1);

    logic [15:0]       base_lo;
    logic [14:0]       base_hi;
    logic [31:0]       pos;
    logic [CNT_W-1:0]  xoff, yoff;
    logic [BA_W-1:0]   ba;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; base_lo <= '0; base_hi <= '0; pos <= '0;
            xoff <= '0; yoff <= '0; fg <= '0; bg <= '0;
            first <= '0; lines <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                3'd0: base_lo <= wr_data;
                3'd1: begin base_hi <= wr_data[14:0]; en <= wr_data[15]; end
                3'd2: pos[15:0] <= wr_data;
                3'd3: pos[31:16] <= wr_data;
                3'd4: xoff <= wr_data[CNT_W-1:0];
                3'd5: yoff <= wr_data[CNT_W-1:0];
                3'd6: begin fg <= wr_data[COL_W-1:0]; bg <= wr_data[8 +: COL_W]; end
                3'd7: begin first <= wr_data[FLD_W-1:0]; lines <= wr_data[8 +: FLD_W]; end
            endcase
        end
    end

    assign base  = ADR_W'({base_hi, base_lo});
    assign ba    = {pos, 2'b00};
    assign cur_y = CNT_W'(ba >> LINE_LG) + yoff;
    assign cur_x = CNT_W'((ba & LMASK) >> PIX_LG) + xoff;
endmodule

// File: rtl/cur_fetch.sv
module cur_fetch
    import cursor_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int ADR_W = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [ADR_W-1:0]     base,
    input  logic [CNT_W-1:0]     cur_y,
    input  logic [FLD_W-1:0]     lines,
    input  logic                 ln_go,
    input  logic [CNT_W-1:0]     ln_y,
    input  logic                 pix_active,
    output logic                 mem_req,
    output logic [ADR_W-1:0]     mem_addr,
    input  logic                 mem_ack,
    input  logic [31:0]          mem_rdata,
    output logic                 show_ok,
    output logic [ROW_BITS-1:0]  row_bits
);
    fetch_st_t          state, nxt;
    logic [WIDX_W-1:0]  wcnt;
    logic [FLD_W-1:0]   row;
    logic [CNT_W-1:0]   drow;
    logic               hit, take;

    assign drow = ln_y - cur_y;
    assign hit  = en && (ln_y >= cur_y) && (drow < CNT_W'(lines));
    assign take = (state == S_FETCH) && mem_ack && !pix_active && !ln_go;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (ln_go) begin
            nxt = hit ? S_FETCH : S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_FETCH: begin
                    if (pix_active)
                        nxt = S_IDLE;
                    else if (mem_ack && wcnt == WIDX_W'(WORDS - 1))
                        nxt = S_SHOW;
                end
                S_SHOW:  nxt = S_SHOW;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = (state == S_FETCH);
        show_ok  = (state == S_SHOW);
        mem_addr = base + ADR_W'({row, wcnt});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            row  <= '0;
        end else if (ln_go) begin
            wcnt <= '0;
            row  <= drow[FLD_W-1:0];
        end else if (take) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                row_bits[w*32 +: 32] <= '0;
            else if (take && wcnt == WIDX_W'(w))
                row_bits[w*32 +: 32] <= mem_rdata;
        end
    end

    a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !pix_active && !ln_go |=> mem_req);
    a_r11_req_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(ln_go));
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && pix_active && !ln_go |=> !mem_req && !show_ok);
endmodule

// File: rtl/cur_mix.sv
module cur_mix
    import cursor_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int COL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 show_ok,
    input  logic                 pix_active,
    input  logic [CNT_W-1:0]     pix_x,
    input  logic [COL_W-1:0]     pix_in,
    input  logic [CNT_W-1:0]     cur_x,
    input  logic [FLD_W-1:0]     first,
    input  logic [COL_W-1:0]     fg,
    input  logic [COL_W-1:0]     bg,
    input  logic [ROW_BITS-1:0]  row_bits,
    output logic [COL_W-1:0]     pix_out
);
    logic [CNT_W-1:0]  dx;
    logic [CNT_W:0]    col_sum;
    logic              in_x;
    logic [FLD_W-1:0]  col;
    code_t             code;
    logic [COL_W-1:0]  mixed;

    always_comb begin
        dx      = pix_x - cur_x;
        col_sum = {1'b0, dx} + (CNT_W+1)'(first);
        in_x    = (pix_x >= cur_x) && (col_sum < (CNT_W+1)'(MAP_DIM));
        col     = col_sum[FLD_W-1:0];
        code    = code_t'(row_bits[{col, 1'b0} +: 2]);
        mixed   = pix_in;
        if (en && show_ok && pix_active && in_x) begin
            unique case (code)
                C_BG:    mixed = bg;
                C_FG:    mixed = fg;
                C_CLEAR: mixed = pix_in;
                C_INV:   mixed = ~pix_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_out <= '0;
        else        pix_out <= mixed;
    end

    a_r9_bypass_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> pix_out == $past(pix_in));
    a_r9_bypass_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active |=> pix_out == $past(pix_in));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int COL_W   = 8,
    parameter int ADR_W   = 31,
    parameter int LINE_LG = 10,
    parameter int PIX_LG  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [15:0]       wr_data,
    input  logic              ln_go,
    input  logic [CNT_W-1:0]  ln_y,
    input  logic              pix_active,
    input  logic [CNT_W-1:0]  pix_x,
    input  logic [COL_W-1:0]  pix_in,
    output logic [COL_W-1:0]  pix_out,
    output logic              mem_req,
    output logic [ADR_W-1:0]  mem_addr,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);
    logic                en, show_ok;
    logic [ADR_W-1:0]    base;
    logic [CNT_W-1:0]    cur_x, cur_y;
    logic [COL_W-1:0]    fg, bg;
    logic [FLD_W-1:0]    first, lines;
    logic [ROW_BITS-1:0] row_bits;

    cur_regs #(.CNT_W(CNT_W), .COL_W(COL_W), .ADR_W(ADR_W),
               .LINE_LG(LINE_LG), .PIX_LG(PIX_LG)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en(en), .base(base), .cur_x(cur_x),
        .cur_y(cur_y), .fg(fg), .bg(bg), .first(first), .lines(lines));

    cur_fetch #(.CNT_W(CNT_W), .ADR_W(ADR_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .en(en), .base(base), .cur_y(cur_y),
        .lines(lines), .ln_go(ln_go), .ln_y(ln_y), .pix_active(pix_active),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .show_ok(show_ok), .row_bits(row_bits));

    cur_mix #(.CNT_W(CNT_W), .COL_W(COL_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .en(en), .show_ok(show_ok),
        .pix_active(pix_active), .pix_x(pix_x), .pix_in(pix_in),
        .cur_x(cur_x), .first(first), .fg(fg), .bg(bg),
        .row_bits(row_bits), .pix_out(pix_out));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> pix_out == '0 && !mem_req);
endmodule

// File: tb/cursor_overlay_test.sv
module cursor_overlay_test;
    localparam int CNT_W = 12;
    localparam int COL_W = 8;
    localparam int ADR_W = 31;
    localparam int WIDTH = 160;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              wr_en = 0;
    logic [2:0]        wr_sel = 0;
    logic [15:0]       wr_data = 0;
    logic              ln_go = 0;
    logic [CNT_W-1:0]  ln_y = 0;
    logic              pix_active = 0;
    logic [CNT_W-1:0]  pix_x = 0;
    logic [COL_W-1:0]  pix_in = 0;
    logic [COL_W-1:0]  pix_out;
    logic              mem_req;
    logic [ADR_W-1:0]  mem_addr;
    logic              mem_ack = 0;
    logic [31:0]       mem_rdata = 0;

    int checks = 0, fails = 0, cycles = 0;
    // bench copy of programmed state
    int m_base = 0, m_cx = 0, m_cy = 0, m_first = 0, m_lines = 0;
    bit m_en = 0;
    logic [7:0] m_fg = 0, m_bg = 0;
    // fetch expectation for the memory model
    bit fetch_exp = 0;
    int exp_row = 0;
    int wc = 0;
    int exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    cursor_overlay uut (.*);

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_at(int r, int c);
        return 2'((r * 3 + c) & 3);
    endfunction

    function automatic logic [31:0] word_for(int r, int w);
        logic [31:0] d;
        for (int j = 0; j < 16; j++) d[2*j +: 2] = code_at(r, 16*w + j);
        return d;
    endfunction

    function automatic logic [7:0] model(int y, int x, bit act, logic [7:0] pin, bit shown);
        int r, k;
        if (!act || !shown || !m_en) return pin;
        r = y - m_cy;
        if (r < 0 || r >= m_lines) return pin;
        k = x - m_cx;
        if (k < 0 || k + m_first > 63) return pin;
        case (code_at(r, k + m_first))
            2'b00: return m_bg;
            2'b01: return m_fg;
            2'b10: return pin;
            default: return ~pin;
        endcase
    endfunction

    // memory model: one-cycle wait per word, checks addresses (R4, R8, R11)
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack = 0; wc = 0;
        end else if (!mem_ack) begin
            if (!fetch_exp)
                chk(0, "R8/R11 request on line without cursor", int'(mem_addr), -1);
            else
                chk(int'(mem_addr) == m_base + 4*exp_row + wc, "R4 map word address",
                    int'(mem_addr), m_base + 4*exp_row + wc);
            mem_rdata = word_for(exp_row, wc);
            mem_ack = 1;
            wc++;
        end else begin
            mem_ack = 0;
        end
    end

    // scoreboard monitor
    always begin
        @(posedge clk); #1;
        if (exp_q.size() > 0) begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(pix_out == 8'(e), t, int'(pix_out), e);
        end
    end

    task automatic wreg(int sel, int data);
        @(negedge clk);
        wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic drive(int y, int x, bit act, bit shown, string tag);
        logic [7:0] pin;
        pin = 8'(x * 7 + y * 13);
        pix_active = act; pix_x = CNT_W'(x); pix_in = pin;
        exp_q.push_back(int'(model(y, x, act, pin, shown)));
        tag_q.push_back(tag);
    endtask

    task automatic run_line(int y, int blank_n, bit shown, string tag);
        int r;
        @(negedge clk);
        r = y - m_cy;
        fetch_exp = m_en && r >= 0 && r < m_lines;
        exp_row = r;
        ln_go = 1; ln_y = CNT_W'(y);
        drive(y, 0, 0, shown, tag);
        for (int i = 0; i < blank_n; i++) begin
            @(negedge clk); ln_go = 0;
            drive(y, 200 + i, 0, shown, tag);
        end
        for (int x = 0; x < WIDTH; x++) begin
            @(negedge clk); ln_go = 0;
            drive(y, x, 1, shown, tag);
        end
        @(negedge clk);
        drive(y, 300, 0, shown, tag);
        @(negedge clk);
        pix_active = 0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(pix_out == 0, "R1 pix_out in reset", int'(pix_out), 0);
        chk(mem_req == 0, "R1 mem_req in reset", int'(mem_req), 0);
        rst_n = 1;
        @(negedge clk);
        chk(pix_out == 0, "R1 pix_out after reset", int'(pix_out), 0);
        chk(mem_req == 0, "R1 mem_req after reset", int'(mem_req), 0);

        // R2: program registers; R3: coarse pos 2064 -> x0=64, y0=8
        wreg(0, 16'h2345);
        wreg(1, 16'h8001);
        wreg(2, 2064);
        wreg(3, 0);
        wreg(4, 5);
        wreg(5, 3);
        wreg(6, 16'h3CA5);
        wreg(7, 16'h0600);
        m_base = 32'h12345; m_en = 1; m_fg = 8'hA5; m_bg = 8'h3C;
        m_first = 0; m_lines = 6;
        m_cx = ((2064 * 4) % 1024) + 5;
        m_cy = ((2064 * 4) / 1024) + 3;

        run_line(10, 12, 1, "R3 line above cursor");
        run_line(11, 12, 1, "R2/R5/R6 first cursor row");
        run_line(13, 12, 1, "R3/R6 cursor row 2");
        run_line(16, 12, 1, "R8 last shown row");
        run_line(17, 12, 1, "R8 row beyond count");

        wreg(7, 16'h060A); m_first = 10;
        run_line(12, 12, 1, "R7 first column 10");
        wreg(7, 16'h063F); m_first = 63;
        run_line(14, 12, 1, "R7 single column");
        wreg(7, 16'h0600); m_first = 0;

        run_line(15, 0, 0, "R10 fetch abandoned");
        run_line(15, 12, 1, "R10 fetch after abandon");

        wreg(1, 16'h0001); m_en = 0;
        run_line(12, 12, 1, "R9 cursor disabled");

        wreg(1, 16'h8001); wreg(4, 100); m_en = 1; m_cx = 64 + 100;
        run_line(11, 12, 1, "R7/R9 cursor at right edge");

        repeat (4) @(negedge clk);
        summary();
    end
endmodule